// File: doc/BRIEF.md
# Serial Real-Time Counter and Backed Memory Slave

This block is a slave on a four-wire serial bus (SPI mode 0, most significant bit first). It holds a 32-bit seconds counter driven by an external once-per-second pulse, a bank of general-purpose backed memory words, a snapshot word, two timer words, a configuration word, four fixed test words and a read-only status word. That status word reports an unstable-power flag and a low-battery flag. Software keeps its time offset in the fourth memory word (address 0x200004) and adds it to the counter value. No calendar conversion happens here.

Every access takes place while chip select is held low and has two 32-bit phases. The first is a command word. Its top bit is the write flag, and bits 30:8 give the register address. The second is the data word. On a read the slave drives the data word out on its output line, and the value was captured when the command word finished. On a write the slave commits the data word when its last bit arrives, and only if the address is writable. Raising chip select at any point discards the access in progress.

All bus pins, the second pulse and the status inputs pass through synchronizers clocked by the system clock. The serial clock is oversampled, so it must stay well below a quarter of the system clock.

Top module: `rtcs_slave`

## Requirements
- R1: A command word carries the write flag in bit 31 (1 = write, 0 = read) and the register address in bits 30:8, with address bit 23 taken as 0. Bits 7:0 are ignored. Both command and data are sampled on rising serial clock edges, most significant bit first.
- R2: After reset the counter and all writable words hold zero, and the serial output is low.
- R3: The counter advances by exactly one on each rising edge of the second pulse and wraps from 0xFFFFFFFF to 0. Without a pulse or a counter write it holds its value.
- R4: A write to address 0x200000 loads the counter. If the write commits in the same cycle as a pulse edge, the written value wins, and the next pulse increments from it.
- R5: A read of address 0x200000 returns the counter value captured at the end of the command phase. A pulse during the data phase does not change the returned word.
- R6: Memory words at 0x200001 to 0x200010, the snapshot word at 0x204000, the timer words at 0x210000 and 0x210001 and the configuration word at 0x21000D read back the last value written to them.
- R7: Test words at 0x210004 to 0x210007 read as TEST_BASE plus (address − 0x210004). Writes to them have no effect.
- R8: The status word at 0x21000C reads with bit 11 equal to the power-unstable input and bit 9 equal to the battery-low input. All its other bits are zero, and writes to it have no effect.
- R9: A read of any unmapped address returns zero, and a write to an unmapped address changes no register.
- R10: Raising chip select resets the phase tracker. An access cut short in either phase writes nothing, and the next access is decoded from its first bit.
- R11: The serial output is driven only during the data phase of a read. At all other times it is low, including during the data phase of a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Serial clock, idle low |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_mosi | input | 1 | Serial data from master |
| spi_miso | output | 1 | Serial data to master |
| sec_tick | input | 1 | Once-per-second pulse; counter steps on its rising edge |
| pwr_unstable | input | 1 | Power-unstable flag, reported in the status word |
| batt_low | input | 1 | Low-battery flag, reported in the status word |

## Verification
Two events can fall in the same cycle: a counter write committing at the end of its data phase, and a rising edge of the second pulse. The bench raises the pulse at the same instant as the last serial clock edge of a counter write. Both signals pass through synchronizers of equal depth, so the two events arrive at the register together. The outcome is judged by reading the counter back, which must return the written value, and again after one more pulse, which must return that value plus one. A pulse placed in the data phase of a counter read also checks that the captured word is not torn.

// File: rtl/rtcs_pkg.sv
package rtcs_pkg;

   localparam int unsigned WORD_W     = 32;
   localparam int unsigned ADDR_W     = 24;
   localparam int unsigned IDX_W      = 4;
   localparam int unsigned TEST_WORDS = 4;

   localparam logic [ADDR_W-1:0] A_COUNT   = 24'h200000;
   localparam logic [ADDR_W-1:0] A_MEM0    = 24'h200001;
   localparam logic [ADDR_W-1:0] A_SNAP    = 24'h204000;
   localparam logic [ADDR_W-1:0] A_TMR_ON  = 24'h210000;
   localparam logic [ADDR_W-1:0] A_TMR_OFF = 24'h210001;
   localparam logic [ADDR_W-1:0] A_TEST0   = 24'h210004;
   localparam logic [ADDR_W-1:0] A_STATUS  = 24'h21000C;
   localparam logic [ADDR_W-1:0] A_CONFIG  = 24'h21000D;

   localparam int unsigned STAT_PWR_BIT  = 11;
   localparam int unsigned STAT_BATT_BIT = 9;

   typedef enum logic [1:0] {
      PH_CMD,
      PH_DATA,
      PH_SPENT
   } phase_t;

   typedef enum logic [3:0] {
      RG_NONE,
      RG_COUNT,
      RG_MEM,
      RG_SNAP,
      RG_TMR_ON,
      RG_TMR_OFF,
      RG_TEST,
      RG_STATUS,
      RG_CONFIG
   } reg_sel_t;

   typedef struct packed {
      reg_sel_t           sel;
      logic [IDX_W-1:0]   idx;
      logic               rd_ok;
      logic               wr_ok;
   } dec_t;

endpackage

// File: rtl/rtcs_sync.sv
module rtcs_sync #(
   parameter int unsigned WIDTH  = 1,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [WIDTH-1:0] stg [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) stg[i] <= '0;
            end else begin
               stg[0] <= d;
               for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
            end
         end
         assign q = stg[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/rtcs_shifter.sv
module rtcs_shifter #(
   parameter int unsigned W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         sck_s,
   input  logic         cs_act,
   input  logic         mosi_s,
   input  logic         load,
   input  logic [W-1:0] load_word,
   output logic         word_done,
   output logic [W-1:0] rx_word,
   output logic         tx_msb
);

   localparam int unsigned CNT_W = (W > 1) ? $clog2(W) : 1;
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(W - 1);

   logic             sck_q;
   logic             rise, fall;
   logic [CNT_W-1:0] bit_cnt;
   logic [W-1:0]     rx_sh;
   logic [W-1:0]     tx_sh;

   assign rise = cs_act &  sck_s & ~sck_q;
   assign fall = cs_act & ~sck_s &  sck_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_q   <= 1'b0;
         bit_cnt <= '0;
         rx_sh   <= '0;
         tx_sh   <= '0;
      end else begin
         sck_q <= sck_s;
         if (!cs_act)   bit_cnt <= '0;
         else if (rise) bit_cnt <= (bit_cnt == LAST_BIT) ? '0 : bit_cnt + 1'b1;
         if (rise) rx_sh <= {rx_sh[W-2:0], mosi_s};
         // the falling edge right after a completed word must not shift
         if (load)                         tx_sh <= load_word;
         else if (fall && bit_cnt != '0)   tx_sh <= {tx_sh[W-2:0], 1'b0};
      end
   end

   assign word_done = rise && (bit_cnt == LAST_BIT);
   assign rx_word   = {rx_sh[W-2:0], mosi_s};
   assign tx_msb    = tx_sh[W-1];

   AST_BITCNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_act |=> (bit_cnt == '0)); // R10

endmodule

// File: rtl/rtcs_decode.sv
module rtcs_decode
   import rtcs_pkg::*;
#(
   parameter int unsigned MEM_WORDS = 16
) (
   input  logic [ADDR_W-1:0] addr,
   output dec_t              dec
);

   localparam logic [ADDR_W-1:0] MEM_END  = A_MEM0 + ADDR_W'(MEM_WORDS);
   localparam logic [ADDR_W-1:0] TEST_END = A_TEST0 + ADDR_W'(TEST_WORDS);

   logic [ADDR_W-1:0] mem_off, test_off;

   assign mem_off  = addr - A_MEM0;
   assign test_off = addr - A_TEST0;

   always_comb begin
      dec = '{sel: RG_NONE, idx: '0, rd_ok: 1'b0, wr_ok: 1'b0};
      if (addr == A_COUNT) begin
         dec = '{sel: RG_COUNT, idx: '0, rd_ok: 1'b1, wr_ok: 1'b1};
      end else if (addr >= A_MEM0 && addr < MEM_END) begin
         dec = '{sel: RG_MEM, idx: mem_off[IDX_W-1:0], rd_ok: 1'b1, wr_ok: 1'b1};
      end else if (addr == A_SNAP) begin
         dec = '{sel: RG_SNAP, idx: '0, rd_ok: 1'b1, wr_ok: 1'b1};
      end else if (addr == A_TMR_ON) begin
         dec = '{sel: RG_TMR_ON, idx: '0, rd_ok: 1'b1, wr_ok: 1'b1};
      end else if (addr == A_TMR_OFF) begin
         dec = '{sel: RG_TMR_OFF, idx: '0, rd_ok: 1'b1, wr_ok: 1'b1};
      end else if (addr >= A_TEST0 && addr < TEST_END) begin
         dec = '{sel: RG_TEST, idx: test_off[IDX_W-1:0], rd_ok: 1'b1, wr_ok: 1'b0};
      end else if (addr == A_STATUS) begin
         dec = '{sel: RG_STATUS, idx: '0, rd_ok: 1'b1, wr_ok: 1'b0};
      end else if (addr == A_CONFIG) begin
         dec = '{sel: RG_CONFIG, idx: '0, rd_ok: 1'b1, wr_ok: 1'b1};
      end
   end

endmodule

// File: rtl/rtcs_regfile.sv
module rtcs_regfile
   import rtcs_pkg::*;
#(
   parameter int unsigned MEM_WORDS = 16,
   parameter logic [WORD_W-1:0] TEST_BASE = 32'h5A5A_0000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              we,
   input  reg_sel_t          wsel,
   input  logic [IDX_W-1:0]  widx,
   input  logic [WORD_W-1:0] wdata,
   input  reg_sel_t          rsel,
   input  logic [IDX_W-1:0]  ridx,
   input  logic              pwr_flag,
   input  logic              batt_flag,
   output logic [WORD_W-1:0] rdata
);

   logic              tick_q, tick_ev, cnt_wr;
   logic [WORD_W-1:0] cnt_q, snap_q, tmr_on_q, tmr_off_q, cfg_q;
   logic [WORD_W-1:0] mem_q [MEM_WORDS];

   assign tick_ev = tick & ~tick_q;
   assign cnt_wr  = we && (wsel == RG_COUNT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tick_q    <= 1'b0;
         cnt_q     <= '0;
         snap_q    <= '0;
         tmr_on_q  <= '0;
         tmr_off_q <= '0;
         cfg_q     <= '0;
      end else begin
         tick_q <= tick;
         if (cnt_wr)       cnt_q <= wdata;
         else if (tick_ev) cnt_q <= cnt_q + 1'b1;
         if (we) begin
            case (wsel)
               RG_SNAP:    snap_q    <= wdata;
               RG_TMR_ON:  tmr_on_q  <= wdata;
               RG_TMR_OFF: tmr_off_q <= wdata;
               RG_CONFIG:  cfg_q     <= wdata;
               default: ;
            endcase
         end
      end
   end

   generate
      for (genvar g = 0; g < MEM_WORDS; g++) begin : g_mem
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) mem_q[g] <= '0;
            else if (we && wsel == RG_MEM && widx == IDX_W'(g)) mem_q[g] <= wdata;
         end
      end
   endgenerate

   always_comb begin
      rdata = '0;
      case (rsel)
         RG_COUNT:   rdata = cnt_q;
         RG_MEM:     rdata = mem_q[ridx];
         RG_SNAP:    rdata = snap_q;
         RG_TMR_ON:  rdata = tmr_on_q;
         RG_TMR_OFF: rdata = tmr_off_q;
         RG_CONFIG:  rdata = cfg_q;
         RG_TEST:    rdata = TEST_BASE + WORD_W'(ridx);
         RG_STATUS: begin
            rdata[STAT_PWR_BIT]  = pwr_flag;
            rdata[STAT_BATT_BIT] = batt_flag;
         end
         default:    rdata = '0;
      endcase
   end

   AST_TICK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_ev && !cnt_wr) |=> (cnt_q == $past(cnt_q) + 32'd1)); // R3
   AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_ev && !cnt_wr) |=> $stable(cnt_q)); // R3
   AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_wr |=> (cnt_q == $past(wdata))); // R4

endmodule

// File: rtl/rtcs_slave.sv
module rtcs_slave
   import rtcs_pkg::*;
#(
   parameter int unsigned MEM_WORDS   = 16,
   parameter int unsigned SYNC_STAGES = 2,
   parameter logic [WORD_W-1:0] TEST_BASE = 32'h5A5A_0000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic spi_sck,
   input  logic spi_cs_n,
   input  logic spi_mosi,
   output logic spi_miso,
   input  logic sec_tick,
   input  logic pwr_unstable,
   input  logic batt_low
);

   localparam int unsigned N_SYNC = 6;

   generate
      if (MEM_WORDS < 1 || MEM_WORDS > 16) begin : g_bad_mem
         $error("rtcs_slave: MEM_WORDS must lie in 1..16");
      end
      if (SYNC_STAGES > 4) begin : g_bad_sync
         $error("rtcs_slave: SYNC_STAGES must not exceed 4");
      end
   endgenerate

   logic [N_SYNC-1:0] raw_in, syn;
   logic sck_s, cs_act, mosi_s, tick_s, pwr_s, batt_s;

   assign raw_in = {batt_low, pwr_unstable, sec_tick, spi_mosi, ~spi_cs_n, spi_sck};

   rtcs_sync #(.WIDTH(N_SYNC), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(raw_in), .q(syn)
   );

   assign {batt_s, pwr_s, tick_s, mosi_s, cs_act, sck_s} = syn;

   logic              word_done, tx_msb, tx_load;
   logic [WORD_W-1:0] rx_word, rdata, load_word;
   logic              cmd_done, data_done, cmd_wr, we;
   logic [ADDR_W-1:0] cmd_addr;
   dec_t              dec_now;

   phase_t            phase_q;
   logic              wr_flag_q, wr_ok_q;
   reg_sel_t          wsel_q;
   logic [IDX_W-1:0]  widx_q;

   assign cmd_done  = word_done && (phase_q == PH_CMD);
   assign data_done = word_done && (phase_q == PH_DATA);
   assign cmd_wr    = rx_word[WORD_W-1];
   assign cmd_addr  = {1'b0, rx_word[WORD_W-2:8]};

   rtcs_decode #(.MEM_WORDS(MEM_WORDS)) u_dec (
      .addr(cmd_addr), .dec(dec_now)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q   <= PH_CMD;
         wr_flag_q <= 1'b0;
         wr_ok_q   <= 1'b0;
         wsel_q    <= RG_NONE;
         widx_q    <= '0;
      end else if (!cs_act) begin
         phase_q <= PH_CMD;
      end else if (cmd_done) begin
         phase_q   <= PH_DATA;
         wr_flag_q <= cmd_wr;
         wr_ok_q   <= dec_now.wr_ok;
         wsel_q    <= dec_now.sel;
         widx_q    <= dec_now.idx;
      end else if (data_done) begin
         phase_q <= PH_SPENT;
      end
   end

   assign we        = data_done && wr_flag_q && wr_ok_q;
   assign tx_load   = cmd_done && !cmd_wr;
   assign load_word = dec_now.rd_ok ? rdata : '0;

   rtcs_regfile #(.MEM_WORDS(MEM_WORDS), .TEST_BASE(TEST_BASE)) u_regs (
      .clk(clk), .rst_n(rst_n), .tick(tick_s),
      .we(we), .wsel(wsel_q), .widx(widx_q), .wdata(rx_word),
      .rsel(dec_now.sel), .ridx(dec_now.idx),
      .pwr_flag(pwr_s), .batt_flag(batt_s), .rdata(rdata)
   );

   rtcs_shifter #(.W(WORD_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .sck_s(sck_s), .cs_act(cs_act), .mosi_s(mosi_s),
      .load(tx_load), .load_word(load_word),
      .word_done(word_done), .rx_word(rx_word), .tx_msb(tx_msb)
   );

   assign spi_miso = cs_act && (phase_q == PH_DATA) && !wr_flag_q && tx_msb;

   AST_CS_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_act |=> (phase_q == PH_CMD)); // R10
   AST_SPENT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_SPENT && cs_act) |=> (phase_q == PH_SPENT)); // R10

endmodule

// File: tb/rtcs_slave_test.sv
module rtcs_slave_test;

   localparam int HALF = 6;
   localparam logic [31:0] TB_TEST_BASE = 32'h5A5A_0000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sck = 1'b0, cs_n = 1'b1, mosi = 1'b0, tick = 1'b0;
   logic pwr = 1'b0, batt = 1'b0;
   logic miso;

   always #2.5 clk = ~clk;

   rtcs_slave uut (
      .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n), .spi_mosi(mosi),
      .spi_miso(miso), .sec_tick(tick), .pwr_unstable(pwr), .batt_low(batt)
   );

   typedef struct { logic [31:0] exp; string tag; } item_t;
   item_t exp_q[$];
   logic [31:0] got_w;
   event rd_ev;
   int n_vec = 0, n_bad = 0;

   logic [31:0] m_cnt = 0, m_snap = 0, m_on = 0, m_off = 0, m_cfg = 0;
   logic [31:0] m_mem [16];

   function automatic logic [31:0] mk_cmd(input logic w, input logic [23:0] a, input logic [7:0] lo);
      return {w, a[22:0], lo};
   endfunction

   function automatic logic [31:0] model_rd(input logic [23:0] a);
      if (a == 24'h200000) return m_cnt;
      if (a >= 24'h200001 && a <= 24'h200010) return m_mem[int'(a - 24'h200001)];
      if (a == 24'h204000) return m_snap;
      if (a == 24'h210000) return m_on;
      if (a == 24'h210001) return m_off;
      if (a >= 24'h210004 && a <= 24'h210007) return TB_TEST_BASE + 32'(a - 24'h210004);
      if (a == 24'h21000C) return (32'(pwr) << 11) | (32'(batt) << 9);
      if (a == 24'h21000D) return m_cfg;
      return 32'h0;
   endfunction

   task automatic model_wr(input logic [23:0] a, input logic [31:0] d);
      if (a == 24'h200000) m_cnt = d;
      else if (a >= 24'h200001 && a <= 24'h200010) m_mem[int'(a - 24'h200001)] = d;
      else if (a == 24'h204000) m_snap = d;
      else if (a == 24'h210000) m_on = d;
      else if (a == 24'h210001) m_off = d;
      else if (a == 24'h21000D) m_cfg = d;
   endtask

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // nbits < 64 cuts the access short
   task automatic xfer(input logic [31:0] cmd, input logic [31:0] dat, input int tick_bit,
                       input int nbits, output logic [31:0] got);
      got = '0;
      @(negedge clk); cs_n = 1'b0;
      repeat (HALF) @(negedge clk);
      for (int i = 0; i < nbits; i++) begin
         mosi = (i < 32) ? cmd[31-i] : dat[63-i];
         repeat (HALF) @(negedge clk);
         if (i >= 32) got[63-i] = miso;
         sck = 1'b1;
         if (i == tick_bit) tick = 1'b1;
         repeat (HALF) @(negedge clk);
         sck = 1'b0; tick = 1'b0;
      end
      repeat (HALF) @(negedge clk);
      cs_n = 1'b1; mosi = 1'b0;
      repeat (2*HALF) @(negedge clk);
   endtask

   task automatic rd(input logic [23:0] a, input int tick_bit, input string tag);
      logic [31:0] g;
      exp_q.push_back('{model_rd(a), tag});
      xfer(mk_cmd(1'b0, a, 8'h00), 32'h0, tick_bit, 64, g);
      got_w = g;
      -> rd_ev;
      if (tick_bit >= 0) m_cnt++;
      @(negedge clk);
   endtask

   task automatic wr(input logic [23:0] a, input logic [31:0] d, input int tick_bit,
                     input logic [7:0] lo, output logic [31:0] g);
      xfer(mk_cmd(1'b1, a, lo), d, tick_bit, 64, g);
      if (tick_bit >= 0 && a != 24'h200000) m_cnt++;
      model_wr(a, d);
   endtask

   task automatic do_tick();
      @(negedge clk); tick = 1'b1;
      repeat (HALF) @(negedge clk); tick = 1'b0;
      repeat (HALF) @(negedge clk);
      m_cnt++;
   endtask

   // monitor: pops the expected item for every completed read
   initial begin
      forever begin
         @(rd_ev);
         n_vec++;
         if (exp_q.size() == 0) begin
            n_bad++;
            $display("FAIL scoreboard: actual %h expected none", got_w);
         end else begin
            item_t it;
            it = exp_q.pop_front();
            if (got_w !== it.exp) begin
               n_bad++;
               $display("FAIL %s: actual %h expected %h", it.tag, got_w, it.exp);
            end
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL R10 watchdog: actual hung expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      logic [31:0] g;
      for (int i = 0; i < 16; i++) m_mem[i] = '0;
      repeat (5) @(negedge clk);
      chk({31'b0, miso}, 32'h0, "R2 miso low in reset");
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      chk({31'b0, miso}, 32'h0, "R11 miso idle low");

      rd(24'h200000, -1, "R2 counter after reset");
      rd(24'h200004, -1, "R2 bias word after reset");
      rd(24'h21000D, -1, "R2 config after reset");

      do_tick(); do_tick(); do_tick();
      rd(24'h200000, -1, "R3 three pulses");

      for (int i = 0; i < 16; i++) wr(24'h200001 + 24'(i), 32'hC0DE_0100 * 32'(i + 1) ^ 32'h0F0F_3C3C, -1, 8'h00, g);
      for (int i = 0; i < 16; i++) rd(24'h200001 + 24'(i), -1, "R6 memory word readback");

      wr(24'h204000, 32'h1357_9BDF, -1, 8'h00, g);
      chk(g, 32'h0, "R11 miso low in write data phase");
      wr(24'h210000, 32'hAAAA_5555, -1, 8'h00, g);
      wr(24'h210001, 32'h0000_FFFF, -1, 8'h00, g);
      wr(24'h21000D, 32'h8000_0001, -1, 8'hA5, g);
      rd(24'h204000, -1, "R6 snapshot");
      rd(24'h210000, -1, "R6 on timer");
      rd(24'h210001, -1, "R6 off timer");
      rd(24'h21000D, -1, "R1 R6 config with nonzero low byte");

      wr(24'h210005, 32'hFFFF_FFFF, -1, 8'h00, g);
      rd(24'h210004, -1, "R7 test word 0");
      rd(24'h210005, -1, "R7 test word 1 after write");
      rd(24'h210007, -1, "R7 test word 3");

      pwr = 1'b1; batt = 1'b0;
      rd(24'h21000C, -1, "R8 power flag");
      pwr = 1'b1; batt = 1'b1;
      rd(24'h21000C, -1, "R8 both flags");
      pwr = 1'b0; batt = 1'b1;
      wr(24'h21000C, 32'hFFFF_FFFF, -1, 8'h00, g);
      rd(24'h21000C, -1, "R8 battery flag after write");

      wr(24'h200011, 32'hDEAD_BEEF, -1, 8'h00, g);
      wr(24'h204001, 32'hDEAD_BEEF, -1, 8'h00, g);
      rd(24'h200011, -1, "R9 unmapped after memory");
      rd(24'h204001, -1, "R9 unmapped near snapshot");
      rd(24'h210002, -1, "R9 unmapped timer gap");
      rd(24'h21000E, -1, "R9 unmapped past config");
      rd(24'h200010, -1, "R9 last memory word untouched");

      wr(24'h200000, 32'hFFFF_FFFE, -1, 8'h00, g);
      rd(24'h200000, -1, "R4 counter load");
      do_tick();
      rd(24'h200000, -1, "R3 counter at max");
      do_tick();
      rd(24'h200000, -1, "R3 counter wrap");

      wr(24'h200000, 32'h1234_5678, -1, 8'h00, g);
      rd(24'h200000, 40, "R5 pulse during read data phase");
      rd(24'h200000, -1, "R5 pulse counted after read");

      wr(24'h200000, 32'hABCD_0000, 63, 8'h00, g);
      rd(24'h200000, -1, "R4 write wins over coincident pulse");
      do_tick();
      rd(24'h200000, -1, "R4 step from loaded value");

      xfer(mk_cmd(1'b1, 24'h200002, 8'h00), 32'h0, -1, 10, g);
      xfer(mk_cmd(1'b1, 24'h200002, 8'h00), 32'hFFFF_0000, -1, 48, g);
      rd(24'h200002, -1, "R10 aborted write leaves word");
      rd(24'h200001, -1, "R10 access after abort");
      chk({31'b0, miso}, 32'h0, "R11 miso low after access");

      repeat (10) @(negedge clk);
      if (exp_q.size() != 0) begin
         n_bad++;
         $display("FAIL scoreboard: actual %0d pending expected 0", exp_q.size());
      end
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule